// File: doc/BRIEF.md
# Memory Device Identification Reader

This block runs the identification handshake that programming equipment performs on a parallel non-volatile memory before it picks a programming flow. On a start pulse it asks the board's supply logic for the identification voltage on a dedicated address line, keeps the logic address bus at zero apart from its lowest bit, and waits a fixed settle time. It then reads two bytes with chip enable and output enable both low. The manufacturer byte comes from address 0 and the device byte from address 1.

The top bit of each returned byte makes the count of ones in the byte odd. The block checks that parity on both bytes and compares them with the expected manufacturer and device codes, which are parameters. It then drops the voltage request and deselects the memory for one cycle before it raises done. The captured bytes, a match flag and a parity-error flag stay valid while done is high. Every wait is a fixed parameter count of clock cycles.

Top module: `id_probe_reader`

## Requirements
- R1: After reset, idVoltReq and done are 0, chipEnN and outEnN are 1, and mfgByte, devByte, idMatch and parityErr are all 0.
- R2: A start pulse raises idVoltReq at the next edge. The memory then stays deselected (chipEnN = 1) for exactly SETTLE_CYC cycles before the first read. While idVoltReq is high, memAddr bits 1 and up are 0.
- R3: The first read uses memAddr = 0 and the second uses memAddr = 1. Each read keeps chipEnN and outEnN low for READ_WAIT cycles, and memDataIn is sampled in the last of those cycles. The first byte appears on mfgByte and the second on devByte.
- R4: parityErr is 1 when either captured byte has an even number of one bits (odd parity, bit 7 as the parity bit).
- R5: idMatch is 1 only when mfgByte equals EXP_MFG (default 01h), devByte equals EXP_DEV (default 9Bh), and both bytes pass the parity check.
- R6: After the second read there is exactly one cycle with idVoltReq = 0, chipEnN = 1 and outEnN = 1, and then done rises. done rises SETTLE_CYC + 2*READ_WAIT + 2 clock edges after the edge that samples the start pulse, counting that edge. done stays high until the next start.
- R7: A start pulse that arrives while a sequence is running is ignored: the timing and the results are those of the running sequence.
- R8: A start pulse taken while done is high clears done, mfgByte, devByte, idMatch and parityErr at the next edge and begins a new sequence.
- R9: chipEnN is low only while idVoltReq is high, and outEnN is low only while chipEnN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts an identification sequence when idle or done |
| memDataIn | input | 8 | Data bus from the memory |
| idVoltReq | output | 1 | Request for the identification voltage on the memory's address line |
| memAddr | output | ADDR_W | Logic address bus to the memory |
| chipEnN | output | 1 | Active-low chip enable |
| outEnN | output | 1 | Active-low output enable |
| mfgByte | output | 8 | Byte captured at address 0 |
| devByte | output | 8 | Byte captured at address 1 |
| idMatch | output | 1 | Both bytes match the expected codes with good parity |
| parityErr | output | 1 | At least one byte failed the odd-parity check |
| done | output | 1 | Sequence complete; results valid |

## Verification
The assertions assume startPulse is synchronous to clk and that memDataIn is stable while the memory is selected. They also assume ADDR_W is at least 2 and both wait counts are at least 1. The bench memory model returns its stored codes only while the voltage request is up and both enables are low, and returns a distinct filler byte otherwise. The bench drives startPulse only on falling edges, one cycle wide. It mixes random bytes with the exact expected codes, single-bit corruptions of them, and a start pulse injected partway through a running sequence.

// File: rtl/id_probe_pkg.sv
package id_probe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_RDLO,
    ST_RDHI,
    ST_RELEASE,
    ST_DONE
  } probe_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;    // restart the wait counter
    logic waitRead;  // 1: compare against read wait, 0: settle wait
    logic clrRes;    // clear captured bytes and flags
    logic capLo;     // capture the byte at address 0
    logic capHi;     // capture the byte at address 1
    logic judge;     // evaluate parity and match
  } probe_strobe_t;

endpackage

// File: rtl/id_probe_datapath.sv
module id_probe_datapath
  import id_probe_pkg::*;
#(
  parameter int        SETTLE_CYC = 8,
  parameter int        READ_WAIT  = 3,
  parameter logic [7:0] EXP_MFG   = 8'h01,
  parameter logic [7:0] EXP_DEV   = 8'h9B
) (
  input  logic          clk,
  input  logic          rstN,
  input  probe_strobe_t strobe,
  input  logic [7:0]    memDataIn,
  output logic          waitDone,
  output logic [7:0]    mfgByte,
  output logic [7:0]    devByte,
  output logic          idMatch,
  output logic          parityErr
);

  localparam int MAX_WAIT = (SETTLE_CYC > READ_WAIT) ? SETTLE_CYC : READ_WAIT;
  localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);
  localparam int N_SLOT   = 2;

  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] waitLimit;

  assign waitLimit = strobe.waitRead ? CNT_W'(READ_WAIT - 1) : CNT_W'(SETTLE_CYC - 1);
  assign waitDone  = (waitCnt == waitLimit);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClr) waitCnt <= '0;
    else                        waitCnt <= waitCnt + 1'b1;
  end

  // per-slot capture and judgement
  logic [7:0]        slotByte [N_SLOT];
  logic [N_SLOT-1:0] slotCap;
  logic [N_SLOT-1:0] slotParOk;
  logic [N_SLOT-1:0] slotEq;
  logic [7:0]        slotExp  [N_SLOT];

  assign slotCap[0] = strobe.capLo;
  assign slotCap[1] = strobe.capHi;
  assign slotExp[0] = EXP_MFG;
  assign slotExp[1] = EXP_DEV;

  for (genvar g = 0; g < N_SLOT; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrRes) slotByte[g] <= '0;
      else if (slotCap[g])        slotByte[g] <= memDataIn;
    end
    assign slotParOk[g] = ^slotByte[g];
    assign slotEq[g]    = (slotByte[g] == slotExp[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrRes) begin
      idMatch   <= 1'b0;
      parityErr <= 1'b0;
    end else if (strobe.judge) begin
      parityErr <= ~&slotParOk;
      idMatch   <= (&slotParOk) & (&slotEq);
    end
  end

  assign mfgByte = slotByte[0];
  assign devByte = slotByte[1];

endmodule

// File: rtl/id_probe_ctrl.sv
module id_probe_ctrl
  import id_probe_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          waitDone,
  output probe_strobe_t strobe,
  output logic          idVoltReq,
  output logic          chipEnN,
  output logic          outEnN,
  output logic          addrLsb,
  output logic          done
);

  probe_state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        strobe.cntClr = 1'b1;
        if (startPulse) begin
          strobe.clrRes = 1'b1;
          nextState     = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (waitDone) begin
          strobe.cntClr = 1'b1;
          nextState     = ST_RDLO;
        end
      end
      ST_RDLO: begin
        strobe.waitRead = 1'b1;
        if (waitDone) begin
          strobe.capLo  = 1'b1;
          strobe.cntClr = 1'b1;
          nextState     = ST_RDHI;
        end
      end
      ST_RDHI: begin
        strobe.waitRead = 1'b1;
        if (waitDone) begin
          strobe.capHi  = 1'b1;
          strobe.cntClr = 1'b1;
          nextState     = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        strobe.judge  = 1'b1;
        strobe.cntClr = 1'b1;
        nextState     = ST_DONE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  logic reading;
  assign reading   = (state == ST_RDLO) || (state == ST_RDHI);
  assign idVoltReq = (state == ST_SETTLE) || reading;
  assign chipEnN   = ~reading;
  assign outEnN    = ~reading;
  assign addrLsb   = (state == ST_RDHI);
  assign done      = (state == ST_DONE);

endmodule

// File: rtl/id_probe_reader.sv
module id_probe_reader
  import id_probe_pkg::*;
#(
  parameter int         ADDR_W     = 19,
  parameter int         SETTLE_CYC = 8,
  parameter int         READ_WAIT  = 3,
  parameter logic [7:0] EXP_MFG    = 8'h01,
  parameter logic [7:0] EXP_DEV    = 8'h9B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [7:0]        memDataIn,
  output logic              idVoltReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              chipEnN,
  output logic              outEnN,
  output logic [7:0]        mfgByte,
  output logic [7:0]        devByte,
  output logic              idMatch,
  output logic              parityErr,
  output logic              done
);

  probe_strobe_t strobe;
  logic          waitDone;
  logic          addrLsb;

  id_probe_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .waitDone   (waitDone),
    .strobe     (strobe),
    .idVoltReq  (idVoltReq),
    .chipEnN    (chipEnN),
    .outEnN     (outEnN),
    .addrLsb    (addrLsb),
    .done       (done)
  );

  id_probe_datapath #(
    .SETTLE_CYC (SETTLE_CYC),
    .READ_WAIT  (READ_WAIT),
    .EXP_MFG    (EXP_MFG),
    .EXP_DEV    (EXP_DEV)
  ) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .memDataIn  (memDataIn),
    .waitDone   (waitDone),
    .mfgByte    (mfgByte),
    .devByte    (devByte),
    .idMatch    (idMatch),
    .parityErr  (parityErr)
  );

  // only the lowest address bit ever toggles during identification
  assign memAddr = ADDR_W'(addrLsb);

endmodule

// File: rtl/id_probe_reader_chk.sv
module id_probe_reader_chk #(
  parameter int         ADDR_W  = 19,
  parameter logic [7:0] EXP_MFG = 8'h01,
  parameter logic [7:0] EXP_DEV = 8'h9B
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              idVoltReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              chipEnN,
  input logic              outEnN,
  input logic [7:0]        mfgByte,
  input logic [7:0]        devByte,
  input logic              idMatch,
  input logic              parityErr,
  input logic              done
);

  // R9
  ce_needs_hv_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chipEnN |-> idVoltReq);

  // R9
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEnN |-> !chipEnN);

  // R2
  upper_addr_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    idVoltReq |-> (memAddr[ADDR_W-1:1] == '0));

  // R3
  first_read_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chipEnN) |-> !memAddr[0]);

  // R6
  release_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(chipEnN) && !$past(idVoltReq) && $past(outEnN)));

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!idVoltReq && chipEnN && outEnN));

  // R5
  match_consistent_chk: assert property (@(posedge clk) disable iff (!rstN)
    idMatch |-> (!parityErr && mfgByte == EXP_MFG && devByte == EXP_DEV));

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && startPulse) |=> (!done && idVoltReq && mfgByte == 8'h00 &&
                              devByte == 8'h00 && !idMatch && !parityErr));

endmodule

bind id_probe_reader id_probe_reader_chk #(
  .ADDR_W  (ADDR_W),
  .EXP_MFG (EXP_MFG),
  .EXP_DEV (EXP_DEV)
) chkInst (.*);

// File: tb/id_probe_reader_test.sv
`timescale 1ns/1ps
module id_probe_reader_test;

  localparam int         ADDR_W     = 19;
  localparam int         SETTLE_CYC = 8;
  localparam int         READ_WAIT  = 3;
  localparam logic [7:0] EXP_MFG    = 8'h01;
  localparam logic [7:0] EXP_DEV    = 8'h9B;
  localparam int         LATENCY    = SETTLE_CYC + 2 * READ_WAIT + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startPulse = 1'b0;
  logic [7:0]        memDataIn;
  logic              idVoltReq;
  logic [ADDR_W-1:0] memAddr;
  logic              chipEnN, outEnN;
  logic [7:0]        mfgByte, devByte;
  logic              idMatch, parityErr, done;

  logic [7:0] modelMfg = 8'h00;
  logic [7:0] modelDev = 8'h00;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // memory model: codes only in identification mode with both enables low
  assign memDataIn = (!chipEnN && !outEnN && idVoltReq) ?
                     (memAddr[0] ? modelDev : modelMfg) :
                     (!chipEnN ? 8'hA5 : 8'hFF);

  id_probe_reader #(
    .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC), .READ_WAIT(READ_WAIT),
    .EXP_MFG(EXP_MFG), .EXP_DEV(EXP_DEV)
  ) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .memDataIn(memDataIn),
    .idVoltReq(idVoltReq), .memAddr(memAddr), .chipEnN(chipEnN), .outEnN(outEnN),
    .mfgByte(mfgByte), .devByte(devByte), .idMatch(idMatch),
    .parityErr(parityErr), .done(done)
  );

  function automatic bit oddPar(input logic [7:0] b);
    return ^b;
  endfunction

  function automatic bit expPerr(input logic [7:0] m, input logic [7:0] d);
    return !oddPar(m) || !oddPar(d);
  endfunction

  function automatic bit expMatch(input logic [7:0] m, input logic [7:0] d);
    return (m == EXP_MFG) && (d == EXP_DEV) && oddPar(m) && oddPar(d);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one full sequence; pokeBusy injects a second start mid-sequence
  task automatic runProbe(input logic [7:0] m, input logic [7:0] d, input bit pokeBusy);
    int n = 0;
    int settleCnt = 0;
    int readCnt = 0;
    int addrBad = 0;
    int oeBad = 0;
    bit seenRead = 0;
    bit prevHv = 1;
    bit prevCe = 0;
    bit firstLsbBad = 0;
    modelMfg = m;
    modelDev = d;
    @(negedge clk);
    startPulse = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    startPulse = 1'b0;
    // R8: results and done cleared by the starting edge
    check(!done && mfgByte == 8'h00 && devByte == 8'h00 && !idMatch && !parityErr,
          "R8 clear on start", {done, mfgByte}, 0);
    // R2: voltage requested right after the start edge
    check(idVoltReq == 1'b1, "R2 request raised", idVoltReq, 1);
    while (n < 200) begin
      if (!chipEnN && !seenRead && memAddr[0]) firstLsbBad = 1;
      if (!chipEnN) seenRead = 1;
      if (idVoltReq && chipEnN && !seenRead) settleCnt++;
      if (!chipEnN) readCnt++;
      if (idVoltReq && (memAddr >> 1) != 0) addrBad++;
      if (!outEnN && chipEnN) oeBad++;
      if (!chipEnN && !idVoltReq) oeBad++;
      if (done) break;
      prevHv = idVoltReq;
      prevCe = chipEnN;
      startPulse = (pokeBusy && n == 5);
      @(posedge clk);
      n++;
      @(negedge clk);
      startPulse = 1'b0;
    end
    check(settleCnt == SETTLE_CYC, "R2 settle cycles", settleCnt, SETTLE_CYC);
    check(addrBad == 0, "R2 upper address zero", addrBad, 0);
    check(readCnt == 2 * READ_WAIT, "R3 read cycles", readCnt, 2 * READ_WAIT);
    check(!firstLsbBad, "R3 address 0 read first", firstLsbBad, 0);
    check(oeBad == 0, "R9 enable ordering", oeBad, 0);
    check(n == LATENCY, pokeBusy ? "R7 busy start ignored latency" : "R6 latency",
          n, LATENCY);
    check(!prevHv && prevCe, "R6 release before done", {prevHv, prevCe}, 1);
    check(mfgByte == m, pokeBusy ? "R7 mfgByte" : "R3 mfgByte", mfgByte, m);
    check(devByte == d, pokeBusy ? "R7 devByte" : "R3 devByte", devByte, d);
    check(parityErr == expPerr(m, d), "R4 parityErr", parityErr, expPerr(m, d));
    check(idMatch == expMatch(m, d), "R5 idMatch", idMatch, expMatch(m, d));
    // R6: done holds while idle
    repeat (3) @(negedge clk);
    check(done && mfgByte == m, "R6 done holds", {done, mfgByte}, {1'b1, m});
  endtask

  initial begin
    logic [7:0] rm, rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!idVoltReq && chipEnN && outEnN && !done, "R1 control outputs",
          {idVoltReq, chipEnN, outEnN, done}, 4'b0110);
    check(mfgByte == 0 && devByte == 0 && !idMatch && !parityErr, "R1 results",
          {mfgByte, devByte}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!idVoltReq && chipEnN && !done, "R1 idle after reset",
          {idVoltReq, chipEnN, done}, 3'b010);

    // directed corners
    runProbe(EXP_MFG, EXP_DEV, 0);          // R5 exact match
    runProbe(EXP_MFG, 8'h9D, 0);            // R5 wrong device, good parity
    runProbe(8'h03, EXP_DEV, 0);            // R4 bad parity manufacturer
    runProbe(EXP_MFG, 8'h9A, 0);            // R4 bad parity device
    runProbe(8'h80, 8'h7F, 0);              // R4 good parity both, no match
    runProbe(EXP_MFG, EXP_DEV, 1);          // R7 start during busy

    // random mix
    for (int i = 0; i < 24; i++) begin
      int sel = $urandom_range(0, 3);
      rm = 8'($urandom);
      rd = 8'($urandom);
      if (sel == 0) begin rm = EXP_MFG; rd = EXP_DEV; end
      else if (sel == 1) begin
        rm = EXP_MFG ^ (8'h01 << $urandom_range(0, 7));
        rd = EXP_DEV;
      end
      runProbe(rm, rd, ($urandom_range(0, 4) == 0));
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule